// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block steers operands and holds the front end of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback). It reads the register specifiers and control bits sitting in the decode, execute, memory and writeback stage registers. From these it decides where each execute-stage operand comes from and whether a store in the memory stage takes its data from the writeback result. It also decides when fetch and decode must freeze for one clock while a nop enters execute.

Only read-after-write conflicts are checked. The in-order five-stage flow cannot produce write-after-write or write-after-read hazards. A load's value exists only at the end of its memory stage. A consumer that needs it in execute directly after the load therefore costs one stall. A store that only writes the loaded value back to memory costs none, because the value is sent into the store's memory stage instead. Writeback enables are never touched: forwarded results still reach the register file.

Top module: `hzd_fwd_unit`

## Requirements
- R1: After reset is released, `fwd_st` is 0. With all stage inputs zero, `stall`, `bubble`, `fwd_a` and `fwd_b` are 0.
- R2: Each execute operand select takes one of three values: 2'b00 for the register file, 2'b10 for the execute/memory result, 2'b01 for the memory/writeback result. When both later stages write the operand's register, 2'b10 wins.
- R3: When only the writeback stage writes an execute operand's register, that operand's select is 2'b01. With no match, it is 2'b00.
- R4: A producer whose destination is register 0, or whose write enable is low, never causes a forward or a stall.
- R5: A load in execute whose destination is read in execute by the decode-stage instruction raises `stall` and `bubble` together in that same cycle. "Read in execute" means rs with `id_use_rs`, or rt with `id_use_rt` on a non-store.
- R6: A store in decode whose data register (rt) is the destination of the load in execute raises no stall. Two clocks later, when the store is in the memory stage, `fwd_st` is 1 for exactly that one cycle.
- R7: A store in decode whose base register (rs) is the load's destination stalls exactly as in R5.
- R8: A load in the memory stage is never chosen as an execute forwarding source (select 2'b10). The select then falls back to the writeback match or the register file.
- R9: The stall lasts one cycle. Once the bubble occupies execute (load bits cleared) and decode still holds the same consumer, `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | AW | Decode-stage first source register |
| id_rt | input | AW | Decode-stage second source register |
| id_use_rs | input | 1 | Decode instruction reads rs |
| id_use_rt | input | 1 | Decode instruction reads rt |
| id_is_store | input | 1 | Decode instruction is a store (rt is store data) |
| ex_rs | input | AW | Execute-stage first source register |
| ex_rt | input | AW | Execute-stage second source register |
| ex_rd | input | AW | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage register write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_is_store | input | 1 | Execute-stage instruction is a store |
| mem_rd | input | AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage register write enable |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage register write enable |
| fwd_a | output | 2 | Execute operand A (rs) source select |
| fwd_b | output | 2 | Execute operand B (rt) source select |
| fwd_st | output | 1 | Memory-stage store data taken from writeback result |
| stall | output | 1 | Hold fetch and decode stage registers |
| bubble | output | 1 | Load a nop into the execute stage |

## Verification
Directed patterns cover several cases:
- a register written by both later stages, to show the newer result wins;
- one written only in writeback;
- matches on register 0 or with the enable low, to show false hits are rejected;
- a load followed by an arithmetic consumer, by a store sharing only its data register, and by a store sharing its base register; these separate the stall path from the memory-stage path.

A two-cycle sequence with the bubble entering execute shows the stall releasing by itself. A seeded random sweep of stage contents is then compared against a bench model built from the select and stall rules.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_opnd_sel.sv
module hzd_opnd_sel
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output fwd_sel_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic hit_mem;
  logic hit_wb;

  // a load in MEM has no value yet; it is never a source here
  assign hit_mem = mem_wen && !mem_load && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign hit_wb  = wb_wen && (wb_rd != ZERO_REG) && (wb_rd == src);

  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  output logic          stall_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic prod_ok;
  logic rs_dep;
  logic rt_dep;

  assign prod_ok = ex_load && ex_wen && (ex_rd != ZERO_REG);
  assign rs_dep  = id_use_rs && (id_rs == ex_rd);
  // store data is served in MEM, so it does not count as a use in EX
  assign rt_dep  = id_use_rt && !id_is_store && (id_rt == ex_rd);
  assign stall_o = prod_ok && (rs_dep || rt_dep);
endmodule

// File: rtl/hzd_st_fwd.sv
module hzd_st_fwd #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_is_store,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  output logic          fwd_st_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic fwd_d;
  logic fwd_q;
  logic fwd_en;

  always_comb begin
    fwd_d  = ex_is_store && mem_load && mem_wen &&
             (mem_rd != ZERO_REG) && (mem_rd == ex_rt);
    fwd_en = ex_is_store || fwd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fwd_q <= 1'b0;
    else if (fwd_en) fwd_q <= fwd_d;
  end

  assign fwd_st_o = fwd_q;
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic          ex_is_store,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          fwd_st,
  output logic          stall,
  output logic          bubble
);
  localparam int NOPND = 2;

  logic [AW-1:0] opnd_src [NOPND];
  fwd_sel_e      opnd_sel [NOPND];
  logic          hold;

  assign opnd_src[0] = ex_rs;
  assign opnd_src[1] = ex_rt;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    hzd_opnd_sel #(.AW(AW)) u_sel (
      .src      (opnd_src[g]),
      .mem_rd   (mem_rd),
      .mem_wen  (mem_wen),
      .mem_load (mem_load),
      .wb_rd    (wb_rd),
      .wb_wen   (wb_wen),
      .sel      (opnd_sel[g])
    );
  end

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  hzd_load_use #(.AW(AW)) u_lu (
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_use_rs   (id_use_rs),
    .id_use_rt   (id_use_rt),
    .id_is_store (id_is_store),
    .ex_rd       (ex_rd),
    .ex_wen      (ex_wen),
    .ex_load     (ex_load),
    .stall_o     (hold)
  );

  assign stall  = hold;
  assign bubble = hold;

  hzd_st_fwd #(.AW(AW)) u_stf (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_is_store (ex_is_store),
    .ex_rt       (ex_rt),
    .mem_rd      (mem_rd),
    .mem_wen     (mem_wen),
    .mem_load    (mem_load),
    .fwd_st_o    (fwd_st)
  );
endmodule

// File: rtl/hzd_fwd_chk.sv
module hzd_fwd_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] id_rs,
  input logic          id_use_rs,
  input logic          id_is_store,
  input logic [AW-1:0] id_rt,
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rt,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic          ex_is_store,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mem_load,
  input logic [AW-1:0] wb_rd,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          fwd_st,
  input logic          stall,
  input logic          bubble
);
  a_r2_mem_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && !mem_load && mem_rd != '0 && mem_rd == ex_rs) |-> fwd_a == 2'b10);

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  a_r4_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == '0 && wb_rd == '0) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r5_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_wen && ex_rd != '0 && id_use_rs && id_rs == ex_rd)
      |-> (stall && bubble));

  a_r6_store_data_free: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_store && id_rt == ex_rd && !(id_use_rs && id_rs == ex_rd)
      && id_rt != '0) |-> !stall);

  a_r6_st_fwd_next: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_store && mem_load && mem_wen && mem_rd != '0 && mem_rd == ex_rt)
      |=> fwd_st);

  a_r8_no_load_src: assert property (@(posedge clk) disable iff (!rst_n)
    mem_load |-> (fwd_a != 2'b10 && fwd_b != 2'b10));
endmodule

bind hzd_fwd_unit hzd_fwd_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .id_rs       (id_rs),
  .id_use_rs   (id_use_rs),
  .id_is_store (id_is_store),
  .id_rt       (id_rt),
  .ex_rs       (ex_rs),
  .ex_rt       (ex_rt),
  .ex_rd       (ex_rd),
  .ex_wen      (ex_wen),
  .ex_load     (ex_load),
  .ex_is_store (ex_is_store),
  .mem_rd      (mem_rd),
  .mem_wen     (mem_wen),
  .mem_load    (mem_load),
  .wb_rd       (wb_rd),
  .fwd_a       (fwd_a),
  .fwd_b       (fwd_b),
  .fwd_st      (fwd_st),
  .stall       (stall),
  .bubble      (bubble)
);

// File: tb/tb_hzd_fwd_unit.sv
`timescale 1ns/1ps
module tb_hzd_fwd_unit;
  localparam int AW = 5;
  localparam time CYC = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic          id_use_rs, id_use_rt, id_is_store;
  logic          ex_wen, ex_load, ex_is_store, mem_wen, mem_load, wb_wen;
  logic [1:0]    fwd_a, fwd_b;
  logic          fwd_st, stall, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  hzd_fwd_unit #(.AW(AW)) dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
    {id_use_rs, id_use_rt, id_is_store} = '0;
    {ex_wen, ex_load, ex_is_store, mem_wen, mem_load, wb_wen} = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int ref_sel(logic [AW-1:0] s);
    if (mem_wen && !mem_load && mem_rd != 0 && mem_rd == s) return 2;
    if (wb_wen && wb_rd != 0 && wb_rd == s) return 1;
    return 0;
  endfunction

  function automatic int ref_stall();
    if (!(ex_load && ex_wen && ex_rd != 0)) return 0;
    if (id_use_rs && id_rs == ex_rd) return 1;
    if (id_use_rt && !id_is_store && id_rt == ex_rd) return 1;
    return 0;
  endfunction

  task automatic t_reset();
    clr(); #1;
    chk("R1", "fwd_st", fwd_st, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "bubble", bubble, 0);
    chk("R1", "fwd_a", fwd_a, 0);
    chk("R1", "fwd_b", fwd_b, 0);
  endtask

  task automatic t_mem_prio();
    clr();
    mem_rd = 5; mem_wen = 1; wb_rd = 5; wb_wen = 1;
    ex_rs = 5; ex_rt = 5; #1;
    chk("R2", "fwd_a both match", fwd_a, 2);
    chk("R2", "fwd_b both match", fwd_b, 2);
  endtask

  task automatic t_wb_only();
    clr();
    mem_rd = 6; mem_wen = 1; wb_rd = 5; wb_wen = 1;
    ex_rs = 5; ex_rt = 7; #1;
    chk("R3", "fwd_a wb match", fwd_a, 1);
    chk("R3", "fwd_b no match", fwd_b, 0);
  endtask

  task automatic t_zero_and_wen();
    clr();
    mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1; #1;
    chk("R4", "fwd_a reg0", fwd_a, 0);
    wb_rd = 3; wb_wen = 0; mem_rd = 3; mem_wen = 0; ex_rt = 3; #1;
    chk("R4", "fwd_b wen low", fwd_b, 0);
    clr();
    ex_load = 1; ex_wen = 1; ex_rd = 0; id_use_rs = 1; id_rs = 0; #1;
    chk("R4", "stall reg0", stall, 0);
    ex_rd = 4; id_rs = 4; ex_wen = 0; #1;
    chk("R4", "stall wen low", stall, 0);
  endtask

  task automatic t_load_use();
    clr();
    ex_load = 1; ex_wen = 1; ex_rd = 4;
    id_rs = 4; id_use_rs = 1; #1;
    chk("R5", "stall rs", stall, 1);
    chk("R5", "bubble rs", bubble, 1);
    id_rs = 9; id_rt = 4; id_use_rt = 1; #1;
    chk("R5", "stall rt", stall, 1);
    id_use_rt = 0; #1;
    chk("R5", "no stall unused rt", stall, 0);
  endtask

  task automatic t_one_cycle();
    clr();
    @(negedge clk);
    ex_load = 1; ex_wen = 1; ex_rd = 4; id_rs = 4; id_use_rs = 1; #1;
    chk("R9", "stall first cycle", stall, 1);
    step();
    ex_load = 0; ex_wen = 0; ex_rd = 0; #1;
    chk("R9", "stall with bubble in EX", stall, 0);
    chk("R9", "bubble with bubble in EX", bubble, 0);
  endtask

  task automatic t_store_fwd();
    clr();
    @(negedge clk);
    id_is_store = 1; id_use_rs = 1; id_use_rt = 1; id_rs = 2; id_rt = 8;
    ex_load = 1; ex_wen = 1; ex_rd = 8; #1;
    chk("R6", "no stall store data", stall, 0);
    step();
    clr();
    ex_is_store = 1; ex_rs = 2; ex_rt = 8;
    mem_load = 1; mem_wen = 1; mem_rd = 8; #1;
    chk("R8", "fwd_b not from load", fwd_b, 0);
    chk("R6", "fwd_st not yet", fwd_st, 0);
    step();
    clr(); #1;
    chk("R6", "fwd_st store in MEM", fwd_st, 1);
    step(); #1;
    chk("R6", "fwd_st one cycle", fwd_st, 0);
  endtask

  task automatic t_store_base();
    clr();
    id_is_store = 1; id_use_rs = 1; id_use_rt = 1; id_rs = 8; id_rt = 3;
    ex_load = 1; ex_wen = 1; ex_rd = 8; #1;
    chk("R7", "stall store base", stall, 1);
    chk("R7", "bubble store base", bubble, 1);
  endtask

  task automatic t_random();
    int bad = 0;
    for (int i = 0; i < 300; i++) begin
      id_rs = AW'($urandom_range(0, 3)); id_rt = AW'($urandom_range(0, 3));
      ex_rs = AW'($urandom_range(0, 3)); ex_rt = AW'($urandom_range(0, 3));
      ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      wb_rd = AW'($urandom_range(0, 3));
      {id_use_rs, id_use_rt, id_is_store} = 3'($urandom);
      {ex_wen, ex_load, mem_wen, mem_load, wb_wen} = 5'($urandom);
      ex_is_store = 1'b0;
      #1;
      if (fwd_a != ref_sel(ex_rs) || fwd_b != ref_sel(ex_rt) ||
          stall != ref_stall() || bubble != ref_stall()) bad++;
    end
    chk("R2", "random mismatches", bad, 0);
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    clr();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_prio();
    t_wb_only();
    t_zero_and_wen();
    t_load_use();
    t_one_cycle();
    t_store_fwd();
    t_store_base();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule